// File: doc/BRIEF.md
# External Host Bus Bridge

This block is a slave port for an external microcontroller-style host. Two active-low chip selects choose the target. The register select reaches a small local register file: page offset, page range, buffer mode and a read-only version word. The memory select forwards the access as one single transfer on a request/done master port toward the internal system bus.

The host-side protocol is set at run time. Three things are configurable: the bus width (16 or 32 bit), the level the ready line uses to signal completion, and the strobe style (separate read and write strobes, or one direction line). These settings are taken from strap pins while power-on reset is held. After reset, only a local CPU can change them, through a small APB-like register port, which also exposes a sticky error flag. The host has no path to that control word.

Each chip-select path applies its own size rules. A rejected access still completes the handshake, so a faulty host access can never hang the bus.

Top module: `hostbus_bridge`

## Requirements
- R1: While `rst_ni` is low, the straps are synchronised and captured. At APB address 0x0, bit 0 reads 1 for a 32-bit host, bit 1 reads the ready polarity and bit 2 reads the combined-strobe mode. Width code 00 selects 16 bit and 01 selects 32 bit. The upper width strap bit is ignored, so 10 acts as 16 bit and 11 acts as 32 bit. Strap changes after reset have no effect.
- R2: `host_rdy_o` sits at its inactive level (the inverse of the polarity bit) when no access is in progress. It takes the polarity level once an access completes. It returns to the inactive level one cycle after both chip selects are released.
- R3: In split mode, an access starts only when a chip select and at least one strobe are low; a low `host_wr_ni` means write. In combined mode, a chip select alone starts the access, `host_rd_ni` is ignored, and `host_wr_ni` low means write while high means read.
- R4: An APB write to address 0x0 replaces the three control bits. Nothing else changes them.
- R5: The register window is decoded on bits [3:2]: 0 is page offset (32 bit), 1 is page range (32 bit), 2 is buffer mode (2 bit, upper bits read 0) and 3 is version (read-only, writes ignored). Addresses 0x10 to 0x3F read zero, ignore writes and raise no error.
- R6: In 16-bit mode, address bit 1 selects the upper (1) or lower (0) halfword, and register data sits on bits [15:0]. In 32-bit mode, address bit 1 is forced to 0 for both register and memory paths.
- R7: On the register path, only halfword accesses (size 1) are allowed in 16-bit mode and only word accesses (size 2) in 32-bit mode, at addresses below 0x40. Any other access completes with read data 0, changes no register and sets the error flag.
- R8: A valid memory access raises `m_req_o` with address, size, direction and write data. These are held until `m_done_i`. Ready stays inactive during this time, and the read data returned is `m_rdata_i` unchanged.
- R9: On the memory path, size 0 is a byte, size 1 a halfword and size 2 a word. A halfword needs address bit 0 clear and a word needs bits [1:0] clear. Words are allowed only in 32-bit mode. A violation completes without a request and sets the error flag.
- R10: If both chip selects are low together, the access completes without a request, with read data 0, and sets the error flag.
- R11: The error flag appears at APB address 0x4, bit 0. It stays set until an APB write to 0x4 with bit 0 set clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Active-low power-on reset |
| strap_width_i | input | 2 | Width strap code |
| strap_rdy_pol_i | input | 1 | Ready polarity strap |
| strap_comb_rw_i | input | 1 | Combined strobe strap |
| apb_sel_i | input | 1 | Local CPU access strobe |
| apb_write_i | input | 1 | Local CPU write |
| apb_addr_i | input | 4 | Local CPU byte address |
| apb_wdata_i | input | 32 | Local CPU write data |
| apb_rdata_o | output | 32 | Local CPU read data |
| host_cs_reg_ni | input | 1 | Register chip select |
| host_cs_mem_ni | input | 1 | Memory chip select |
| host_rd_ni | input | 1 | Read strobe (split mode) |
| host_wr_ni | input | 1 | Write strobe or direction line |
| host_size_i | input | 2 | Access size |
| host_addr_i | input | 16 | Host byte address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data |
| host_rdy_o | output | 1 | Completion indicator |
| m_req_o | output | 1 | Master transfer request |
| m_write_o | output | 1 | Master transfer direction |
| m_addr_o | output | 16 | Master address |
| m_size_o | output | 2 | Master transfer size |
| m_wdata_o | output | 32 | Master write data |
| m_rdata_i | input | 32 | Master read data |
| m_done_i | input | 1 | Master transfer complete |

## Verification
The assertions assume that host signals are synchronous to `clk_i` and stay stable from chip-select assertion until the host sees ready. They also assume that `m_done_i` is raised only while `m_req_o` is high. The stimulus changes all host and APB inputs only on falling edges. The bench's master responder raises done for exactly one cycle, two cycles after it sees a request.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} hb_size_e;

  typedef struct packed {
    logic wide;
    logic rdy_pol;
    logic comb_rw;
  } hb_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_DONE} hb_state_e;
endpackage

// File: rtl/hb_cfg.sv
module hb_cfg
  import hb_pkg::*;
#(
  parameter int DW = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    strap_width_i,
  input  logic          strap_rdy_pol_i,
  input  logic          strap_comb_rw_i,
  input  logic          apb_sel_i,
  input  logic          apb_write_i,
  input  logic [3:0]    apb_addr_i,
  input  logic [DW-1:0] apb_wdata_i,
  output logic [DW-1:0] apb_rdata_o,
  input  logic          err_set_i,
  output hb_cfg_t       cfg_o
);
  localparam int NS = 3;

  logic [NS-1:0] sync_q [SYNC_STAGES];
  hb_cfg_t       cfg_q;
  logic          err_q;
  logic          ctrl_wr, err_clr;

  // upper width strap bit dropped: no 8-bit host
  always_ff @(posedge clk_i) begin
    sync_q[0] <= {strap_width_i[0], strap_rdy_pol_i, strap_comb_rw_i};
    for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
  end

  assign ctrl_wr = apb_sel_i && apb_write_i && (apb_addr_i[3:2] == 2'd0);
  assign err_clr = apb_sel_i && apb_write_i && (apb_addr_i[3:2] == 2'd1) && apb_wdata_i[0];

  // loads from straps only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni)      cfg_q <= sync_q[SYNC_STAGES-1];
    else if (ctrl_wr) cfg_q <= {apb_wdata_i[0], apb_wdata_i[1], apb_wdata_i[2]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (err_set_i) err_q <= 1'b1;
    else if (err_clr)   err_q <= 1'b0;
  end

  always_comb begin
    apb_rdata_o = '0;
    case (apb_addr_i[3:2])
      2'd0: apb_rdata_o[2:0] = {cfg_q.comb_rw, cfg_q.rdy_pol, cfg_q.wide};
      2'd1: apb_rdata_o[0]   = err_q;
      default: ;
    endcase
  end

  assign cfg_o = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(cfg_q)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr) |=> err_q); // R11
endmodule

// File: rtl/hb_regs.sv
module hb_regs #(
  parameter int          DW      = 32,
  parameter int          BUF_W   = 2,
  parameter logic [31:0] VERSION = 32'h0002_0105
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          wide_i,
  input  logic [5:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0]    page_off_q, page_rng_q, word;
  logic [BUF_W-1:0] buf_mode_q;
  logic             in_map, upper;

  assign in_map = (addr_i[5:4] == 2'd0);
  assign upper  = !wide_i && addr_i[1];

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d,
                                          logic wide, logic up);
    if (wide)    return d;
    else if (up) return {d[HW-1:0], old[HW-1:0]};
    else         return {old[DW-1:HW], d[HW-1:0]};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_off_q <= '0;
      page_rng_q <= '0;
      buf_mode_q <= '0;
    end else if (we_i && in_map) begin
      case (addr_i[3:2])
        2'd0: page_off_q <= merge(page_off_q, wdata_i, wide_i, upper);
        2'd1: page_rng_q <= merge(page_rng_q, wdata_i, wide_i, upper);
        2'd2: if (!upper) buf_mode_q <= wdata_i[BUF_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i[3:2])
      2'd0:    word = page_off_q;
      2'd1:    word = page_rng_q;
      2'd2:    word = DW'(buf_mode_q);
      default: word = VERSION[DW-1:0];
    endcase
    if (!in_map)     rdata_o = '0;
    else if (wide_i) rdata_o = word;
    else             rdata_o = {{HW{1'b0}}, upper ? word[DW-1:HW] : word[HW-1:0]};
  end

  AST_VER_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 6'h0C && wide_i) |=> (addr_i != 6'h0C || !wide_i || rdata_o == VERSION[DW-1:0])); // R5
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  hb_cfg_t           cfg_i,
  input  logic              cs_reg_ni,
  input  logic              cs_mem_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rdy_o,
  output logic              reg_we_o,
  output logic [5:0]        reg_addr_o,
  input  logic [DW-1:0]     reg_rdata_i,
  output logic              err_set_o,
  output logic              m_req_o,
  output logic              m_write_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [1:0]        m_size_o,
  output logic [DW-1:0]     m_wdata_o,
  input  logic [DW-1:0]     m_rdata_i,
  input  logic              m_done_i
);
  localparam int REG_SPAN_W = 6;

  hb_state_e         state_q;
  logic [ADDR_W-1:0] eff_addr, m_addr_q;
  logic [DW-1:0]     rdata_q, m_wdata_q;
  logic [1:0]        m_size_q;
  logic              m_write_q;
  logic              sel, both, strobe, is_write, start;
  logic              reg_ok, mem_ok, aligned, reg_go, mem_go, bad;

  always_comb begin
    eff_addr    = addr_i;
    eff_addr[1] = cfg_i.wide ? 1'b0 : addr_i[1];
  end

  assign sel      = !cs_reg_ni || !cs_mem_ni;
  assign both     = !cs_reg_ni && !cs_mem_ni;
  assign strobe   = cfg_i.comb_rw ? sel : (sel && (!rd_ni || !wr_ni));
  assign is_write = !wr_ni;
  assign start    = (state_q == ST_IDLE) && strobe;

  assign reg_ok  = (size_i == (cfg_i.wide ? SZ_WORD : SZ_HALF)) &&
                   (eff_addr[ADDR_W-1:REG_SPAN_W] == '0);
  assign aligned = (size_i == SZ_BYTE) ||
                   (size_i == SZ_HALF && !eff_addr[0]) ||
                   (size_i == SZ_WORD && eff_addr[1:0] == 2'b00);
  assign mem_ok  = aligned && (size_i != SZ_WORD || cfg_i.wide) && (size_i != 2'd3);

  assign reg_go = start && !both && !cs_reg_ni && reg_ok;
  assign mem_go = start && !both && !cs_mem_ni && mem_ok;
  assign bad    = start && !reg_go && !mem_go;

  assign reg_we_o   = reg_go && is_write;
  assign reg_addr_o = eff_addr[REG_SPAN_W-1:0];
  assign err_set_o  = bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rdata_q   <= '0;
      m_addr_q  <= '0;
      m_size_q  <= '0;
      m_write_q <= 1'b0;
      m_wdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          if (mem_go) begin
            m_addr_q  <= eff_addr;
            m_size_q  <= size_i;
            m_write_q <= is_write;
            m_wdata_q <= wdata_i;
            state_q   <= ST_MEM;
          end else begin
            rdata_q <= (reg_go && !is_write) ? reg_rdata_i : '0;
            state_q <= ST_DONE;
          end
        end
        ST_MEM: if (m_done_i) begin
          rdata_q <= m_write_q ? '0 : m_rdata_i;
          state_q <= ST_DONE;
        end
        default: if (!sel) state_q <= ST_IDLE;
      endcase
    end
  end

  assign rdy_o     = (state_q == ST_DONE) ? cfg_i.rdy_pol : !cfg_i.rdy_pol;
  assign rdata_o   = rdata_q;
  assign m_req_o   = (state_q == ST_MEM);
  assign m_write_o = m_write_q;
  assign m_addr_o  = m_addr_q;
  assign m_size_o  = m_size_q;
  assign m_wdata_o = m_wdata_q;

  AST_BOTH_NO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && both) |=> !m_req_o); // R10
  AST_BAD_NO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !cs_mem_ni && !mem_ok) |=> !m_req_o); // R9
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && !m_done_i) |=> (m_req_o && $stable(m_addr_o) && $stable(m_wdata_o))); // R8
  AST_RDY_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o |-> (rdy_o != cfg_i.rdy_pol)); // R8
  AST_RDY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel && (state_q == ST_DONE)) |=> (rdy_o != cfg_i.rdy_pol)); // R2
endmodule

// File: rtl/hostbus_bridge.sv
module hostbus_bridge
  import hb_pkg::*;
#(
  parameter int          DW      = 32,
  parameter int          ADDR_W  = 16,
  parameter int          BUF_W   = 2,
  parameter logic [31:0] VERSION = 32'h0002_0105
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        strap_width_i,
  input  logic              strap_rdy_pol_i,
  input  logic              strap_comb_rw_i,
  input  logic              apb_sel_i,
  input  logic              apb_write_i,
  input  logic [3:0]        apb_addr_i,
  input  logic [DW-1:0]     apb_wdata_i,
  output logic [DW-1:0]     apb_rdata_o,
  input  logic              host_cs_reg_ni,
  input  logic              host_cs_mem_ni,
  input  logic              host_rd_ni,
  input  logic              host_wr_ni,
  input  logic [1:0]        host_size_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DW-1:0]     host_wdata_i,
  output logic [DW-1:0]     host_rdata_o,
  output logic              host_rdy_o,
  output logic              m_req_o,
  output logic              m_write_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [1:0]        m_size_o,
  output logic [DW-1:0]     m_wdata_o,
  input  logic [DW-1:0]     m_rdata_i,
  input  logic              m_done_i
);
  hb_cfg_t       cfg;
  logic          err_set, reg_we;
  logic [5:0]    reg_addr;
  logic [DW-1:0] reg_rdata;

  hb_cfg #(.DW(DW)) u_cfg (
    .clk_i, .rst_ni, .strap_width_i, .strap_rdy_pol_i, .strap_comb_rw_i,
    .apb_sel_i, .apb_write_i, .apb_addr_i, .apb_wdata_i, .apb_rdata_o,
    .err_set_i(err_set), .cfg_o(cfg)
  );

  hb_regs #(.DW(DW), .BUF_W(BUF_W), .VERSION(VERSION)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we), .wide_i(cfg.wide), .addr_i(reg_addr),
    .wdata_i(host_wdata_i), .rdata_o(reg_rdata)
  );

  hb_ctrl #(.DW(DW), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .cfg_i(cfg),
    .cs_reg_ni(host_cs_reg_ni), .cs_mem_ni(host_cs_mem_ni),
    .rd_ni(host_rd_ni), .wr_ni(host_wr_ni), .size_i(host_size_i),
    .addr_i(host_addr_i), .wdata_i(host_wdata_i), .rdata_o(host_rdata_o),
    .rdy_o(host_rdy_o), .reg_we_o(reg_we), .reg_addr_o(reg_addr),
    .reg_rdata_i(reg_rdata), .err_set_o(err_set),
    .m_req_o, .m_write_o, .m_addr_o, .m_size_o, .m_wdata_o, .m_rdata_i, .m_done_i
  );
endmodule

// File: tb/hostbus_bridge_test.sv
module hostbus_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VER = 32'h0002_0105;

  logic        clk = 0, rst_n = 0;
  logic [1:0]  strap_w = 2'b10;
  logic        strap_p = 0, strap_c = 0;
  logic        apb_sel = 0, apb_wr = 0;
  logic [3:0]  apb_addr = 0;
  logic [31:0] apb_wdata = 0, apb_rdata;
  logic        cs_reg_n = 1, cs_mem_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0]  size = 0;
  logic [15:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        rdy;
  logic        m_req, m_write, m_done = 0;
  logic [15:0] m_addr;
  logic [1:0]  m_size;
  logic [31:0] m_wdata, m_rdata = 0;

  int checks = 0, fails = 0, fwd_cnt = 0, lat = 0;
  logic [15:0] last_addr;
  logic [1:0]  last_size;
  logic        last_write;
  logic [31:0] last_wdata;
  logic        pol = 0, comb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostbus_bridge uut (
    .clk_i(clk), .rst_ni(rst_n), .strap_width_i(strap_w), .strap_rdy_pol_i(strap_p),
    .strap_comb_rw_i(strap_c), .apb_sel_i(apb_sel), .apb_write_i(apb_wr),
    .apb_addr_i(apb_addr), .apb_wdata_i(apb_wdata), .apb_rdata_o(apb_rdata),
    .host_cs_reg_ni(cs_reg_n), .host_cs_mem_ni(cs_mem_n), .host_rd_ni(rd_n),
    .host_wr_ni(wr_n), .host_size_i(size), .host_addr_i(addr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .host_rdy_o(rdy), .m_req_o(m_req), .m_write_o(m_write),
    .m_addr_o(m_addr), .m_size_o(m_size), .m_wdata_o(m_wdata), .m_rdata_i(m_rdata),
    .m_done_i(m_done)
  );

  // master responder: done two cycles after request
  always @(negedge clk) begin
    if (m_done) m_done = 0;
    else if (m_req) begin
      if (lat == 1) begin
        m_done = 1; m_rdata = {16'hC0DE, m_addr}; fwd_cnt++;
        last_addr = m_addr; last_size = m_size; last_write = m_write; last_wdata = m_wdata;
        lat = 0;
      end else lat++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] w, input logic p, input logic c);
    rst_n = 0; strap_w = w; strap_p = p; strap_c = c;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    pol = p; comb = c;
  endtask

  task automatic apb_write(input logic [3:0] a, input logic [31:0] d);
    apb_sel = 1; apb_wr = 1; apb_addr = a; apb_wdata = d;
    @(negedge clk);
    apb_sel = 0; apb_wr = 0;
  endtask

  task automatic apb_read(input logic [3:0] a, output logic [31:0] d);
    apb_addr = a; #1; d = apb_rdata;
  endtask

  task automatic host_acc(input bit mem, input bit dual, input bit wr, input logic [1:0] sz,
                          input logic [15:0] a, input logic [31:0] d, output logic [31:0] q);
    int n = 0;
    addr = a; size = sz; wdata = d;
    cs_reg_n = mem && !dual; cs_mem_n = !mem && !dual;
    if (comb) begin rd_n = 1; wr_n = !wr; end
    else begin rd_n = wr; wr_n = !wr; end
    @(negedge clk);
    while (rdy !== pol && n < 20) begin @(negedge clk); n++; end
    chk(n < 20, "R2 ready timeout", 32'(rdy), 32'(pol));
    q = rdata;
    cs_reg_n = 1; cs_mem_n = 1; rd_n = 1; wr_n = 1;
    @(negedge clk);
    chk(rdy === !pol, "R2 ready release", 32'(rdy), 32'(!pol));
  endtask

  task automatic t_reset;
    logic [31:0] v;
    apb_read(4'h0, v);
    chk(v == 32'h0, "R1 strap 10 -> 16-bit", v, 32'h0);
    chk(rdy === 1'b1, "R2 idle ready", 32'(rdy), 32'h1);
    chk(m_req === 1'b0, "R8 no req at reset", 32'(m_req), 32'h0);
    strap_w = 2'b01; strap_p = 1; strap_c = 1;
    repeat (4) @(negedge clk);
    apb_read(4'h0, v);
    chk(v == 32'h0, "R1 straps ignored after reset", v, 32'h0);
  endtask

  task automatic t_reg16;
    logic [31:0] q;
    host_acc(0, 0, 1, 2'd1, 16'h0000, 32'h0000_1234, q);
    host_acc(0, 0, 1, 2'd1, 16'h0002, 32'h0000_ABCD, q);
    host_acc(0, 0, 0, 2'd1, 16'h0000, 0, q);
    chk(q == 32'h1234, "R6 low half", q, 32'h1234);
    host_acc(0, 0, 0, 2'd1, 16'h0002, 0, q);
    chk(q == 32'hABCD, "R6 high half", q, 32'hABCD);
    host_acc(0, 0, 0, 2'd1, 16'h000E, 0, q);
    chk(q == 32'h0002, "R5 version upper half", q, 32'h0002);
    host_acc(0, 0, 0, 2'd1, 16'h0010, 0, q);
    chk(q == 32'h0, "R5 reserved reads zero", q, 0);
    apb_read(4'h4, q);
    chk(q == 32'h0, "R5 reserved no error", q, 0);
  endtask

  task automatic t_reject16;
    logic [31:0] q;
    host_acc(0, 0, 1, 2'd0, 16'h0000, 32'h55, q);
    apb_read(4'h4, q);
    chk(q == 32'h1, "R7 byte sets error", q, 1);
    host_acc(0, 0, 0, 2'd1, 16'h0000, 0, q);
    chk(q == 32'h1234, "R7 byte write discarded", q, 32'h1234);
    apb_read(4'h4, q);
    chk(q == 32'h1, "R11 error sticky", q, 1);
    host_acc(0, 0, 0, 2'd2, 16'h0000, 0, q);
    chk(q == 32'h0, "R7 word in 16-bit reads zero", q, 0);
    apb_write(4'h4, 32'h1);
    apb_read(4'h4, q);
    chk(q == 32'h0, "R11 error cleared", q, 0);
    host_acc(0, 0, 0, 2'd1, 16'h0040, 0, q);
    chk(q == 32'h0, "R7 address 0x40 reads zero", q, 0);
    apb_read(4'h4, q);
    chk(q == 32'h1, "R7 address 0x40 error", q, 1);
    apb_write(4'h4, 32'h1);
  endtask

  task automatic t_mem16;
    logic [31:0] q;
    int f0 = fwd_cnt;
    host_acc(1, 0, 1, 2'd1, 16'h0102, 32'h0000_BEEF, q);
    chk(fwd_cnt == f0 + 1, "R8 halfword forwarded", fwd_cnt, f0 + 1);
    chk(last_addr == 16'h0102 && last_write && last_size == 2'd1, "R8 write attributes",
        {last_addr, 14'h0, last_size}, {16'h0102, 16'h1});
    chk(last_wdata == 32'h0000_BEEF, "R8 write data", last_wdata, 32'hBEEF);
    host_acc(1, 0, 0, 2'd0, 16'h0103, 0, q);
    chk(q == 32'hC0DE_0103, "R8 byte read data", q, 32'hC0DE_0103);
    chk(fwd_cnt == f0 + 2, "R9 byte allowed", fwd_cnt, f0 + 2);
    host_acc(1, 0, 0, 2'd2, 16'h0100, 0, q);
    chk(fwd_cnt == f0 + 2, "R9 word in 16-bit rejected", fwd_cnt, f0 + 2);
    host_acc(1, 0, 0, 2'd1, 16'h0101, 0, q);
    chk(fwd_cnt == f0 + 2, "R9 misaligned half rejected", fwd_cnt, f0 + 2);
    apb_read(4'h4, q);
    chk(q == 32'h1, "R9 error set", q, 1);
    apb_write(4'h4, 32'h1);
  endtask

  task automatic t_both;
    logic [31:0] q;
    int f0 = fwd_cnt;
    host_acc(1, 1, 0, 2'd1, 16'h0000, 0, q);
    chk(fwd_cnt == f0, "R10 nothing forwarded", fwd_cnt, f0);
    chk(q == 32'h0, "R10 read zero", q, 0);
    apb_read(4'h4, q);
    chk(q == 32'h1, "R10 error set", q, 1);
    apb_write(4'h4, 32'h1);
  endtask

  task automatic t_split_idle;
    int f0 = fwd_cnt;
    bit stay = 1;
    cs_mem_n = 0; addr = 16'h0200; size = 2'd1;
    repeat (6) begin @(negedge clk); if (rdy !== 1'b1) stay = 0; end
    cs_mem_n = 1;
    @(negedge clk);
    chk(stay && fwd_cnt == f0, "R3 chip select without strobe idle", fwd_cnt, f0);
  endtask

  task automatic t_override;
    logic [31:0] q;
    apb_write(4'h0, 32'h7);
    pol = 1; comb = 1;
    apb_read(4'h0, q);
    chk(q == 32'h7, "R4 control override", q, 32'h7);
    chk(rdy === 1'b0, "R2 idle ready with pol 1", 32'(rdy), 0);
    host_acc(0, 0, 0, 2'd2, 16'h0000, 0, q);
    chk(q == 32'hABCD_1234, "R3 combined read word", q, 32'hABCD_1234);
    host_acc(0, 0, 1, 2'd2, 16'h0004, 32'hDEAD_BEEF, q);
    host_acc(0, 0, 0, 2'd2, 16'h0006, 0, q);
    chk(q == 32'hDEAD_BEEF, "R6 bit1 forced in 32-bit", q, 32'hDEAD_BEEF);
    host_acc(0, 0, 1, 2'd2, 16'h0008, 32'hFF, q);
    host_acc(0, 0, 0, 2'd2, 16'h0008, 0, q);
    chk(q == 32'h3, "R5 buffer mode width", q, 32'h3);
    host_acc(0, 0, 1, 2'd2, 16'h000C, 32'h0, q);
    host_acc(0, 0, 0, 2'd2, 16'h000C, 0, q);
    chk(q == VER, "R5 version read-only", q, VER);
    host_acc(0, 0, 0, 2'd1, 16'h0000, 0, q);
    chk(q == 32'h0, "R7 half in 32-bit rejected", q, 0);
    apb_write(4'h4, 32'h1);
    host_acc(1, 0, 1, 2'd2, 16'h0202, 32'h1111_2222, q);
    chk(last_addr == 16'h0200 && last_size == 2'd2, "R6 mem word addr forced",
        {last_addr, 14'h0, last_size}, {16'h0200, 16'h2});
    apb_read(4'h0, q);
    chk(q == 32'h7, "R4 control unchanged by host", q, 32'h7);
  endtask

  task automatic t_strap2;
    logic [31:0] q;
    do_reset(2'b11, 1, 1);
    apb_read(4'h0, q);
    chk(q == 32'h7, "R1 strap 11 -> 32-bit", q, 32'h7);
    host_acc(0, 0, 0, 2'd2, 16'h0000, 0, q);
    chk(q == 32'h0, "R1 regs cleared by reset", q, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(2'b10, 0, 0);
    t_reset();
    t_reg16();
    t_reject16();
    t_mem16();
    t_both();
    t_split_idle();
    t_override();
    t_strap2();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule